// File: doc/BRIEF.md
# ALU Status-Flag Generator

This unit produces and stores the status flags of a 16-bit ALU. Each cycle it takes the two operands, the result the datapath produced from them, a two-bit operation class and a byte/word size select. When the update enable is high, it registers six status flags derived from them: carry, parity, auxiliary carry, zero, sign and overflow. For byte operations the flags are taken at bit 7, and bits 15:8 of the operands and of the result are ignored.

The unit also holds three control flags: interrupt enable, string direction and single-step trap. They change only on an explicit set or clear command, never as a side effect of an ALU operation. The interrupt-enable flag masks the maskable interrupt request on its way to the core. All flags leave the unit as one packed vector with fixed bit positions. A flag update becomes visible on the clock edge that samples the enable.

Top module: `alu_flag_unit`

## Requirements
- R1: While `rstN` is low and after it is released, `flagsOut` reads all zeros until the first update or command. The layout is bit0 carry, bit1 parity, bit2 auxiliary carry, bit3 zero, bit4 sign, bit5 overflow, bit6 interrupt enable, bit7 direction, bit8 trap.
- R2: After an add (`opClass`=0), carry is the carry out of the top bit of the operation size (bit 7 when `byteOp`=1, else bit 15). After a subtract (`opClass`=1), carry is 1 exactly when the unsigned first operand is smaller than the second (a borrow).
- R3: After an add, auxiliary carry is the carry from bit 3 into bit 4. After a subtract, it is the borrow from bit 4 into bit 3 (low nibble of A smaller than low nibble of B).
- R4: Zero is 1 exactly when the result is zero over the operation size. Sign equals the top result bit of the operation size. For byte operations, bits 15:8 have no effect on any flag.
- R5: Parity is 1 when result bits 7:0 hold an even number of ones and 0 when that number is odd, for both sizes.
- R6: After an add or subtract, overflow is 1 exactly when the true signed result lies outside the two's-complement range of the operation size.
- R7: After a logic operation (`opClass`=2), carry and overflow are 0 and auxiliary carry keeps its previous value.
- R8: After a shift (`opClass`=3), carry equals `shiftOut`, overflow is 1 when the top result bit differs from the top bit of `opA`, and auxiliary carry keeps its previous value.
- R9: When `updEn` is low, the six status flags keep their values.
- R10: A command with `ctlEn`=1 writes `ctlVal` into the control flag chosen by `ctlSel` (0 interrupt enable, 1 direction, 2 trap; 3 selects nothing). Without a command, the control flags keep their values, including across ALU updates.
- R11: `irqOut` is high exactly when `irqIn` is high and the interrupt-enable flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| opA | input | 16 | First ALU operand |
| opB | input | 16 | Second ALU operand |
| result | input | 16 | ALU result for opA, opB |
| opClass | input | 2 | 0 add, 1 subtract, 2 logic, 3 shift |
| byteOp | input | 1 | 1 selects an 8-bit operation |
| shiftOut | input | 1 | Bit shifted out by the shifter |
| updEn | input | 1 | Load the status flags this cycle |
| ctlEn | input | 1 | Apply a control-flag command this cycle |
| ctlSel | input | 2 | Control flag to write |
| ctlVal | input | 1 | Value to write |
| irqIn | input | 1 | Maskable interrupt request |
| flagsOut | output | 9 | Registered flag vector |
| irqOut | output | 1 | Masked interrupt request |

## Verification
A wrong status bit appears on `flagsOut` one clock after the update that produced it, and it persists until the next update. For this reason the bench compares the whole vector after every operation. A stale auxiliary carry surfaces only after a logic or shift step that should preserve it, so those steps follow adds that leave it set. A corrupted control flag can hide through any number of ALU updates, but it shows at `irqOut` at once or in the next full vector compare.

// File: rtl/flagunit_pkg.sv
package flagunit_pkg;
  localparam int DATA_W  = 16;
  localparam int BYTE_W  = 8;
  localparam int CTL_N   = 3;
  localparam int STAT_N  = 6;
  localparam int FLAG_N  = STAT_N + CTL_N;

  localparam int F_CARRY = 0;
  localparam int F_PAR   = 1;
  localparam int F_AUX   = 2;
  localparam int F_ZERO  = 3;
  localparam int F_SIGN  = 4;
  localparam int F_OVF   = 5;
  localparam int F_INTEN = 6;

  typedef enum logic [1:0] {
    OP_ADD   = 2'd0,
    OP_SUB   = 2'd1,
    OP_LOGIC = 2'd2,
    OP_SHIFT = 2'd3
  } opClass_e;

  typedef struct packed {
    logic             ldStatus;
    logic             ldAux;
    logic             isSub;
    logic             isLogic;
    logic             isShift;
    logic [CTL_N-1:0] ctlSet;
    logic [CTL_N-1:0] ctlClr;
  } flagStrobe_t;
endpackage

// File: rtl/flag_ctrl.sv
module flag_ctrl
  import flagunit_pkg::*;
(
  input  logic        updEn,
  input  logic [1:0]  opClass,
  input  logic        ctlEn,
  input  logic [1:0]  ctlSel,
  input  logic        ctlVal,
  output flagStrobe_t strobe
);
  opClass_e cls;
  logic [CTL_N-1:0] selHot;

  assign cls = opClass_e'(opClass);

  always_comb begin
    case (ctlSel)
      2'd0:    selHot = 3'b001;
      2'd1:    selHot = 3'b010;
      2'd2:    selHot = 3'b100;
      default: selHot = 3'b000;
    endcase
  end

  always_comb begin
    strobe          = '0;
    strobe.ldStatus = updEn;
    strobe.ldAux    = updEn && (cls == OP_ADD || cls == OP_SUB);
    strobe.isSub    = (cls == OP_SUB);
    strobe.isLogic  = (cls == OP_LOGIC);
    strobe.isShift  = (cls == OP_SHIFT);
    if (ctlEn) begin
      if (ctlVal) strobe.ctlSet = selHot;
      else        strobe.ctlClr = selHot;
    end
  end
endmodule

// File: rtl/flag_datapath.sv
module flag_datapath
  import flagunit_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] result,
  input  logic              byteOp,
  input  logic              shiftOut,
  input  flagStrobe_t       strobe,
  output logic [FLAG_N-1:0] flagsQ
);
  localparam int TOP_W = DATA_W - 1;
  localparam int TOP_B = BYTE_W - 1;

  logic aTop, bTop, rTop;
  logic zeroNx, parityNx, auxNx, carryNx, ovfNx;
  logic addCarry, subBorrow, addOvf, subOvf;
  logic [STAT_N-1:0] statusQ;
  logic [CTL_N-1:0]  ctlQ;

  assign aTop = byteOp ? opA[TOP_B] : opA[TOP_W];
  assign bTop = byteOp ? opB[TOP_B] : opB[TOP_W];
  assign rTop = byteOp ? result[TOP_B] : result[TOP_W];

  assign zeroNx   = byteOp ? (result[TOP_B:0] == '0) : (result == '0);
  assign parityNx = ~^result[TOP_B:0];
  assign auxNx    = opA[4] ^ opB[4] ^ result[4];

  assign addCarry  = (aTop & bTop) | (aTop & ~rTop) | (bTop & ~rTop);
  assign subBorrow = (~aTop & bTop) | (~aTop & rTop) | (bTop & rTop);
  assign addOvf    = (aTop == bTop) && (rTop != aTop);
  assign subOvf    = (aTop != bTop) && (rTop != aTop);

  always_comb begin
    if (strobe.isLogic) begin
      carryNx = 1'b0;
      ovfNx   = 1'b0;
    end else if (strobe.isShift) begin
      carryNx = shiftOut;
      ovfNx   = rTop ^ aTop;
    end else if (strobe.isSub) begin
      carryNx = subBorrow;
      ovfNx   = subOvf;
    end else begin
      carryNx = addCarry;
      ovfNx   = addOvf;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
    end else if (strobe.ldStatus) begin
      statusQ[F_CARRY] <= carryNx;
      statusQ[F_PAR]   <= parityNx;
      statusQ[F_ZERO]  <= zeroNx;
      statusQ[F_SIGN]  <= rTop;
      statusQ[F_OVF]   <= ovfNx;
      if (strobe.ldAux) statusQ[F_AUX] <= auxNx;
    end
  end

  for (genvar k = 0; k < CTL_N; k++) begin : gCtl
    always_ff @(posedge clk) begin
      if (!rstN)                 ctlQ[k] <= 1'b0;
      else if (strobe.ctlSet[k]) ctlQ[k] <= 1'b1;
      else if (strobe.ctlClr[k]) ctlQ[k] <= 1'b0;
    end
  end

  assign flagsQ = {ctlQ, statusQ};
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import flagunit_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] opA,
  input  logic [15:0] opB,
  input  logic [15:0] result,
  input  logic [1:0]  opClass,
  input  logic        byteOp,
  input  logic        shiftOut,
  input  logic        updEn,
  input  logic        ctlEn,
  input  logic [1:0]  ctlSel,
  input  logic        ctlVal,
  input  logic        irqIn,
  output logic [8:0]  flagsOut,
  output logic        irqOut
);
  flagStrobe_t strobe;

  flag_ctrl u_ctrl (
    .updEn(updEn), .opClass(opClass), .ctlEn(ctlEn),
    .ctlSel(ctlSel), .ctlVal(ctlVal), .strobe(strobe)
  );

  flag_datapath u_dp (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .result(result),
    .byteOp(byteOp), .shiftOut(shiftOut), .strobe(strobe), .flagsQ(flagsOut)
  );

  assign irqOut = irqIn & flagsOut[F_INTEN];
endmodule

// File: rtl/alu_flag_chk.sv
module alu_flag_chk (
  input logic        clk,
  input logic        rstN,
  input logic [15:0] opA,
  input logic [15:0] opB,
  input logic [15:0] result,
  input logic [1:0]  opClass,
  input logic        byteOp,
  input logic        shiftOut,
  input logic        updEn,
  input logic        ctlEn,
  input logic [1:0]  ctlSel,
  input logic        ctlVal,
  input logic        irqIn,
  input logic [8:0]  flagsOut,
  input logic        irqOut
);
  AST_HOLD_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    !updEn |=> $stable(flagsOut[5:0])); // R9

  AST_LOGIC_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (updEn && opClass == 2'd2) |=> (!flagsOut[0] && !flagsOut[5])); // R7

  AST_LOGIC_KEEPS_AUX: assert property (@(posedge clk) disable iff (!rstN)
    (updEn && opClass == 2'd2) |=> $stable(flagsOut[2])); // R7

  AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ctlEn |=> $stable(flagsOut[8:6])); // R10

  AST_PARITY: assert property (@(posedge clk) disable iff (!rstN)
    updEn |=> (flagsOut[1] == ~^$past(result[7:0]))); // R5

  AST_ZERO_SIZE: assert property (@(posedge clk) disable iff (!rstN)
    (updEn && byteOp) |=> (flagsOut[3] == ($past(result[7:0]) == 8'h00))); // R4

  AST_SHIFT_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    (updEn && opClass == 2'd3) |=> (flagsOut[0] == $past(shiftOut))); // R8

  AST_IRQ_MASK: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (irqIn && flagsOut[6])); // R11
endmodule

bind alu_flag_unit alu_flag_chk u_chk (.*);

// File: tb/sim_alu_flag_unit.sv
module sim_alu_flag_unit;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] opA = '0, opB = '0, result = '0;
  logic [1:0]  opClass = '0, ctlSel = '0;
  logic byteOp = 1'b0, shiftOut = 1'b0, updEn = 1'b0;
  logic ctlEn = 1'b0, ctlVal = 1'b0, irqIn = 1'b0;
  logic [8:0] flagsOut;
  logic irqOut;

  int checks = 0;
  int fails  = 0;
  logic [8:0] expF = '0;

  always #(PERIOD/2) clk = ~clk;

  alu_flag_unit u0 (.*);

  task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [8:0] model(input logic [1:0] cls, input logic bop,
      input logic [15:0] a, input logic [15:0] b, input logic [15:0] r,
      input logic sh, input logic [8:0] prev);
    int mask, half, am, bm, rm, sa, sb, s;
    logic [8:0] f;
    mask = bop ? 255 : 65535;
    half = bop ? 128 : 32768;
    am = int'(a) & mask;
    bm = int'(b) & mask;
    rm = int'(r) & mask;
    sa = (am >= half) ? am - 2*half : am;
    sb = (bm >= half) ? bm - 2*half : bm;
    f = prev;
    f[3] = (rm == 0);
    f[4] = ((rm & half) != 0);
    f[1] = ($countones(r[7:0]) % 2 == 0);
    case (cls)
      2'd0: begin
        f[0] = (am + bm) > mask;
        f[2] = ((am & 15) + (bm & 15)) > 15;
        s = sa + sb;
        f[5] = (s >= half) || (s < -half);
      end
      2'd1: begin
        f[0] = am < bm;
        f[2] = (am & 15) < (bm & 15);
        s = sa - sb;
        f[5] = (s >= half) || (s < -half);
      end
      2'd2: begin f[0] = 1'b0; f[5] = 1'b0; end
      default: begin
        f[0] = sh;
        f[5] = ((rm & half) != 0) != ((am & half) != 0);
      end
    endcase
    return f;
  endfunction

  task automatic runOp(input string tag, input logic [1:0] cls, input logic bop,
      input logic [15:0] a, input logic [15:0] b, input logic [15:0] r, input logic sh);
    @(negedge clk);
    opClass = cls; byteOp = bop; opA = a; opB = b; result = r; shiftOut = sh; updEn = 1'b1;
    expF = model(cls, bop, a, b, r, sh, expF);
    @(negedge clk);
    updEn = 1'b0;
    check(tag, flagsOut, expF);
  endtask

  task automatic ctlCmd(input logic [1:0] sel, input logic val);
    @(negedge clk);
    ctlEn = 1'b1; ctlSel = sel; ctlVal = val;
    if (sel != 2'd3) expF[6 + int'(sel)] = val;
    @(negedge clk);
    ctlEn = 1'b0;
    check("R10 control command", flagsOut, expF);
  endtask

  initial begin
    #(PERIOD * 190000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [15:0] a, b, r;
    repeat (3) @(negedge clk);
    check("R1 reset in progress", flagsOut, 9'h000);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after reset", flagsOut, 9'h000);

    // Byte add and subtract sweep; high bytes hold junk (R4)
    for (int i = 0; i < 256; i++) begin
      for (int j = 0; j < 256; j += 5) begin
        a = {8'h5A, 8'(i)};
        b = {8'hC3, 8'(j)};
        r = {8'hA5, 8'(i + j)};
        runOp("R2 R3 R4 R5 R6 byte add", 2'd0, 1'b1, a, b, r, 1'b0);
        r = {8'h3C, 8'(i - j)};
        runOp("R2 R3 R4 R5 R6 byte sub", 2'd1, 1'b1, a, b, r, 1'b0);
      end
    end

    // Word add and subtract, pseudo-random plus corners
    for (int i = 0; i < 3000; i++) begin
      a = 16'(i * 40503 + 7);
      b = 16'(i * 7919 + 12345);
      if (i == 0) begin a = 16'h7FFF; b = 16'h0001; end
      if (i == 1) begin a = 16'hFFFF; b = 16'h0001; end
      if (i == 2) begin a = 16'h8000; b = 16'h8000; end
      if (i == 3) begin a = 16'h0000; b = 16'h0000; end
      runOp("R2 R3 R4 R5 R6 word add", 2'd0, 1'b0, a, b, a + b, 1'b0);
      runOp("R2 R3 R4 R5 R6 word sub", 2'd1, 1'b0, a, b, a - b, 1'b0);
    end

    // Logic keeps aux: first force aux to 1 with 0x0F+0x01 (R7)
    runOp("R3 aux set", 2'd0, 1'b1, 16'h000F, 16'h0001, 16'h0010, 1'b0);
    runOp("R7 logic keeps aux", 2'd2, 1'b1, 16'h00F0, 16'h000F, 16'h0000, 1'b0);
    check("R7 aux still set", {8'h00, flagsOut[2]}, 9'h001);
    for (int i = 0; i < 512; i++) begin
      a = 16'(i * 977 + 3);
      b = 16'(i * 331 + 9);
      runOp("R7 logic", 2'd2, i[0], a, b, a & b, 1'b0);
      runOp("R8 shift", 2'd3, i[1], a, b, a << 1, i[0] ? a[7] : a[15]);
    end

    // Updates disabled: inputs move, status holds (R9)
    @(negedge clk);
    opClass = 2'd0; byteOp = 1'b0; opA = 16'hFFFF; opB = 16'hFFFF; result = 16'h0000;
    repeat (2) @(negedge clk);
    check("R9 hold without update", flagsOut, expF);

    // Control flags (R10) and interrupt mask (R11)
    irqIn = 1'b1;
    @(negedge clk);
    check("R11 masked while disabled", {8'h00, irqOut}, 9'h000);
    for (int s = 0; s < 4; s++) ctlCmd(2'(s), 1'b1);
    runOp("R10 ctl survives add", 2'd0, 1'b0, 16'h1234, 16'h4321, 16'h5555, 1'b0);
    check("R11 passes when enabled", {8'h00, irqOut}, 9'h001);
    irqIn = 1'b0;
    #1 check("R11 low request", {8'h00, irqOut}, 9'h000);
    irqIn = 1'b1;
    ctlCmd(2'd1, 1'b0);
    ctlCmd(2'd3, 1'b0);
    ctlCmd(2'd0, 1'b0);
    check("R11 masked after clear", {8'h00, irqOut}, 9'h000);
    ctlCmd(2'd2, 1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule